// File: doc/BRIEF.md
# Dual Register-Mapped Interval Timer

This peripheral holds one or two independent 32-bit interval timers behind a simple word-addressed register port. Each timer has a control/status word, a load word and a read-only live counter. Software writes a start value into the load word, then writes the control word with the enable bit set. The timer then counts once per clock, either downwards to zero or upwards to all-ones. When it reaches that end value it expires and sets a sticky interrupt flag. On expiry it either reloads and keeps running, or stops and drops its own enable bit, so a read shows the timer as idle.

The flag is cleared by writing a one to it. Each timer's flag is masked by that timer's interrupt-enable bit, and the masked flags are OR'd onto a single interrupt line. A build parameter chooses whether one timer or two are present. Reads are combinational: the read data follows the address in the same cycle.

Top module: `interval_timer`

## Requirements
- R1: After reset every register of every timer reads zero and the interrupt output is low.
- R2: Word 0 of a timer block is control/status. Bits 0 to 7, 9 and 10 read back as written. Bit 8 is the interrupt flag. Bits 31 to 11 read zero. Bit 1 = 1 selects counting down, bit 4 is auto-reload, bit 6 is interrupt enable and bit 7 is timer enable.
- R3: Word 1 is the load register, a full 32-bit read/write value.
- R4: A control write with bit 7 set restarts the timer. The counter (word 2) holds the load value right after that write, and reads return the live count, which changes by one on every clock while enabled.
- R5: In down mode the timer expires in the clock cycle where its count is zero.
- R6: In up mode the timer expires in the clock cycle where its count is all-ones.
- R7: On expiry with auto-reload set, the counter is reloaded from the load register and the timer keeps running.
- R8: On expiry without auto-reload, the count holds and the timer clears its own enable bit.
- R9: A control write with bit 8 set clears the interrupt flag. A control write with bit 8 clear leaves the flag unchanged.
- R10: An expiry in the same cycle as a flag-clearing write wins, so the flag ends up set.
- R11: The interrupt output is high exactly when some timer has both its flag and its interrupt-enable bit set.
- R12: Address bits above the two word-select bits pick the timer (timer 0 at words 0 to 3, timer 1 at words 4 to 7). Word 3 reads zero. Writes to word 3 or to the counter word are ignored. With a single timer, the second block reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address (bits 1:0 word, upper bits timer) |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| irqOut | output | 1 | Shared interrupt |

## Verification
The assertions assume that there is at most one register access per cycle, and that a write reaches exactly one word of one timer, so a restart and a reload can only collide through a control write. They also assume that a flag-clearing write with no expiry in the same cycle is the only way a flag can fall. The stimulus issues single-cycle writes separated by idle cycles. It times one control write to land on an expiry cycle so that the priority rule is exercised, and it leaves the bus idle between accesses so that the counting rules hold on their own.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CSR_W    = 11;
  localparam int BIT_MODE = 0;
  localparam int BIT_DOWN = 1;
  localparam int BIT_GEN  = 2;
  localparam int BIT_CAPT = 3;
  localparam int BIT_ARLD = 4;
  localparam int BIT_LDRQ = 5;
  localparam int BIT_IEN  = 6;
  localparam int BIT_EN   = 7;
  localparam int BIT_FLAG = 8;
  localparam int BIT_PWM  = 9;
  localparam int BIT_ALL  = 10;

  // control bits that store the written value directly (all but the flag)
  localparam logic [CSR_W-1:0] CSR_KEEP = ~(CSR_W'(1) << BIT_FLAG);

  localparam logic [1:0] SLOT_CTRL  = 2'd0;
  localparam logic [1:0] SLOT_LOAD  = 2'd1;
  localparam logic [1:0] SLOT_COUNT = 2'd2;
  localparam logic [1:0] SLOT_RSVD  = 2'd3;

  typedef struct packed {
    logic run;      // timer enabled, count this cycle
    logic down;     // direction
    logic restart;  // load counter from load register
    logic reload;   // reload on expiry instead of stopping
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                busValid,
  input  logic                                busWrite,
  input  logic [ADDR_W-1:0]                   busAddr,
  input  logic [DATA_W-1:0]                   busWdata,
  input  logic [NUM_TIMERS-1:0][DATA_W-1:0]   cntVec,
  input  logic [NUM_TIMERS-1:0]               hitVec,
  output tmrStrobe_t [NUM_TIMERS-1:0]         strobeVec,
  output logic [NUM_TIMERS-1:0][DATA_W-1:0]   loadVec,
  output logic [NUM_TIMERS-1:0]               flagVec,
  output logic [NUM_TIMERS-1:0]               ienVec,
  output logic [DATA_W-1:0]                   busRdata
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] selIdx;
  logic [1:0]       slotIdx;
  assign selIdx  = busAddr[ADDR_W-1:2];
  assign slotIdx = busAddr[1:0];

  logic [NUM_TIMERS-1:0][CSR_W-1:0] csrVec;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic              hereWr, wrCtrl, wrLoad;
    logic [CSR_W-1:0]  csrQ, csrD;
    logic [DATA_W-1:0] loadQ;

    assign hereWr = busValid && busWrite && (selIdx == SEL_W'(t));
    assign wrCtrl = hereWr && (slotIdx == SLOT_CTRL);
    assign wrLoad = hereWr && (slotIdx == SLOT_LOAD);

    always_comb begin
      csrD = csrQ;
      if (hitVec[t] && !csrQ[BIT_ARLD]) csrD[BIT_EN] = 1'b0;
      if (wrCtrl) begin
        csrD = (busWdata[CSR_W-1:0] & CSR_KEEP) | (csrQ & ~CSR_KEEP);
        if (busWdata[BIT_FLAG]) csrD[BIT_FLAG] = 1'b0;
      end
      // expiry outranks a clearing write
      if (hitVec[t]) csrD[BIT_FLAG] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        csrQ  <= '0;
        loadQ <= '0;
      end else begin
        csrQ <= csrD;
        if (wrLoad) loadQ <= busWdata;
      end
    end

    assign csrVec[t]            = csrQ;
    assign loadVec[t]           = loadQ;
    assign flagVec[t]           = csrQ[BIT_FLAG];
    assign ienVec[t]            = csrQ[BIT_IEN];
    assign strobeVec[t].run     = csrQ[BIT_EN];
    assign strobeVec[t].down    = csrQ[BIT_DOWN];
    assign strobeVec[t].restart = wrCtrl && busWdata[BIT_EN];
    assign strobeVec[t].reload  = csrQ[BIT_ARLD];
  end

  always_comb begin
    busRdata = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (selIdx == SEL_W'(t)) begin
        case (slotIdx)
          SLOT_CTRL:  busRdata = DATA_W'(csrVec[t]);
          SLOT_LOAD:  busRdata = loadVec[t];
          SLOT_COUNT: busRdata = cntVec[t];
          default:    busRdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  tmrStrobe_t [NUM_TIMERS-1:0]       strobeVec,
  input  logic [NUM_TIMERS-1:0][DATA_W-1:0] loadVec,
  output logic [NUM_TIMERS-1:0][DATA_W-1:0] cntVec,
  output logic [NUM_TIMERS-1:0]             hitVec
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_cnt
    logic [DATA_W-1:0] cntQ;
    tmrStrobe_t        stb;
    logic              atEnd;

    assign stb       = strobeVec[t];
    assign atEnd     = stb.down ? (cntQ == '0) : (cntQ == ALL_ONES);
    assign hitVec[t] = stb.run && atEnd;
    assign cntVec[t] = cntQ;

    always_ff @(posedge clk) begin
      if (!rstN)              cntQ <= '0;
      else if (stb.restart)   cntQ <= loadVec[t];
      else if (hitVec[t]) begin
        if (stb.reload)       cntQ <= loadVec[t];
      end
      else if (stb.run)       cntQ <= stb.down ? cntQ - 1'b1 : cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter bit TWO_TIMERS = 1'b1,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  localparam int NUM_TIMERS = TWO_TIMERS ? 2 : 1;

  tmrStrobe_t [NUM_TIMERS-1:0]       strobeVec;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] loadVec;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] cntVec;
  logic [NUM_TIMERS-1:0]             hitVec;
  logic [NUM_TIMERS-1:0]             flagVec;
  logic [NUM_TIMERS-1:0]             ienVec;

  tmr_ctrl #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .cntVec(cntVec), .hitVec(hitVec),
    .strobeVec(strobeVec), .loadVec(loadVec), .flagVec(flagVec),
    .ienVec(ienVec), .busRdata(busRdata)
  );

  tmr_count #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W)) uCount (
    .clk(clk), .rstN(rstN), .strobeVec(strobeVec), .loadVec(loadVec),
    .cntVec(cntVec), .hitVec(hitVec)
  );

  assign irqOut = |(flagVec & ienVec);
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              busValid,
  input logic                              busWrite,
  input logic [ADDR_W-1:0]                 busAddr,
  input logic                              wdFlag,
  input tmrStrobe_t [NUM_TIMERS-1:0]       strobeVec,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0] loadVec,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0] cntVec,
  input logic [NUM_TIMERS-1:0]             hitVec,
  input logic [NUM_TIMERS-1:0]             flagVec
);
  localparam int SEL_W = ADDR_W - 2;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chk
    logic wrCtrl, wrCount;
    assign wrCtrl  = busValid && busWrite && busAddr[ADDR_W-1:2] == SEL_W'(t)
                     && busAddr[1:0] == SLOT_CTRL;
    assign wrCount = busValid && busWrite && busAddr[ADDR_W-1:2] == SEL_W'(t)
                     && busAddr[1:0] == SLOT_COUNT;

    // R4
    restart_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobeVec[t].restart |=> cntVec[t] == $past(loadVec[t]));

    // R5
    down_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobeVec[t].run && strobeVec[t].down && !hitVec[t] && !wrCtrl
      |=> cntVec[t] == $past(cntVec[t]) - 1'b1);

    // R6
    up_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobeVec[t].run && !strobeVec[t].down && !hitVec[t] && !wrCtrl
      |=> cntVec[t] == $past(cntVec[t]) + 1'b1);

    // R7
    reload_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[t] && strobeVec[t].reload && !wrCtrl
      |=> strobeVec[t].run && cntVec[t] == $past(loadVec[t]));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[t] && !strobeVec[t].reload && !wrCtrl
      |=> !strobeVec[t].run && $stable(cntVec[t]));

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrCtrl && wdFlag && !hitVec[t] |=> !flagVec[t]);

    // R10
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[t] |=> flagVec[t]);

    // R12
    count_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrCount && !strobeVec[t].run |=> $stable(cntVec[t]));
  end
endmodule

bind interval_timer tmr_chk #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .wdFlag(busWdata[BIT_FLAG]), .strobeVec(strobeVec),
  .loadVec(loadVec), .cntVec(cntVec), .hitVec(hitVec), .flagVec(flagVec)
);

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  interval_timer u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // behavioural reference: per timer control bits, flag, load, count
  logic [31:0] mCtl [2];
  logic        mFlag [2];
  logic [31:0] mLoad [2];
  logic [31:0] mCnt [2];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < 2; t++) begin
        mCtl[t] = 0; mFlag[t] = 0; mLoad[t] = 0; mCnt[t] = 0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        automatic bit en  = mCtl[t][7];
        automatic bit dn  = mCtl[t][1];
        automatic bit ar  = mCtl[t][4];
        automatic bit hit = en && (dn ? (mCnt[t] == 0) : (mCnt[t] == 32'hFFFF_FFFF));
        automatic bit wr  = busValid && busWrite && busAddr[2] == t[0];
        automatic bit wc  = wr && busAddr[1:0] == 2'd0;
        automatic bit wl  = wr && busAddr[1:0] == 2'd1;
        automatic logic [31:0] nCtl = mCtl[t];
        automatic logic [31:0] nCnt = mCnt[t];
        automatic bit nFlag = mFlag[t];
        if (hit && !ar) nCtl[7] = 1'b0;
        if (wc) begin
          nCtl = busWdata & 32'h6FF;
          if (busWdata[8]) nFlag = 1'b0;
        end
        if (hit) nFlag = 1'b1;
        if (wc && busWdata[7]) nCnt = mLoad[t];
        else if (hit) nCnt = ar ? mLoad[t] : mCnt[t];
        else if (en) nCnt = dn ? mCnt[t] - 1 : mCnt[t] + 1;
        mCtl[t] = nCtl; mFlag[t] = nFlag; mCnt[t] = nCnt;
        if (wl) mLoad[t] = busWdata;
      end
    end
  end

  function automatic logic [31:0] expRead(logic [2:0] a);
    automatic int t = a[2];
    case (a[1:0])
      2'd0: return mCtl[t] | (32'(mFlag[t]) << 8);
      2'd1: return mLoad[t];
      2'd2: return mCnt[t];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference (R2 R3 R4 R11 live)
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 live read vs model", busRdata, expRead(busAddr));
      chk("R11 irq vs model", 32'(irqOut), 32'((mFlag[0] && mCtl[0][6]) || (mFlag[1] && mCtl[1][6])));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    busAddr = a;
    #1;
    chk(tag, busRdata, exp);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 reset read");
    chk("R1 irq after reset", 32'(irqOut), 32'h0);

    // R2 control readback, upper bits and flag position
    wr(3'd0, 32'hFFFF_FE7F);
    rd(3'd0, 32'h0000_067F, "R2 ctrl readback");
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h0, "R2 ctrl cleared");

    // R3 load, R12 counter and reserved writes ignored
    wr(3'd1, 32'd5);
    rd(3'd1, 32'd5, "R3 load readback");
    wr(3'd2, 32'h1234);
    rd(3'd2, 32'h0, "R12 counter write ignored");
    wr(3'd3, 32'hABCD);
    rd(3'd3, 32'h0, "R12 reserved reads zero");

    // R4 R5 R8 down count, one-shot
    wr(3'd0, 32'h82);
    rd(3'd2, 32'd5, "R4 restart value");
    cyc(3);
    rd(3'd2, 32'd2, "R4 live count");
    cyc(10);
    rd(3'd0, 32'h102, "R5 R8 expired and idle");
    rd(3'd2, 32'd0, "R8 count holds");
    chk("R11 masked irq", 32'(irqOut), 32'h0);

    // R9 flag write semantics
    wr(3'd0, 32'h002);
    rd(3'd0, 32'h102, "R9 zero leaves flag");
    wr(3'd0, 32'h100);
    rd(3'd0, 32'h000, "R9 one clears flag");

    // R6 R7 R11 R12 timer 1 up, auto-reload
    wr(3'd5, 32'hFFFF_FFFD);
    rd(3'd1, 32'd5, "R12 timer0 load untouched");
    wr(3'd4, 32'hD0);
    rd(3'd6, 32'hFFFF_FFFD, "R6 start");
    cyc(3);
    rd(3'd6, 32'hFFFF_FFFD, "R7 reloaded");
    rd(3'd4, 32'h1D0, "R6 R7 flag set, still enabled");
    chk("R11 irq high", 32'(irqOut), 32'h1);

    // R10 clearing write lands on an expiry cycle
    cyc(1);
    wr(3'd4, 32'h1D0);
    rd(3'd4, 32'h1D0, "R10 expiry wins");
    chk("R10 irq stays", 32'(irqOut), 32'h1);
    rd(3'd6, 32'hFFFF_FFFD, "R10 restart value");

    // R9 R11 clear and stop timer 1
    wr(3'd4, 32'h100);
    rd(3'd4, 32'h0, "R9 timer1 cleared");
    chk("R11 irq low", 32'(irqOut), 32'h0);
    rd(3'd7, 32'h0, "R12 timer1 reserved");
    cyc(2);
    finishRun();
  end
endmodule